// File: doc/BRIEF.md
# Oversampling Serial Receiver with Per-Character Error Queue

This block recovers asynchronous serial characters from a single receive line. A free-running oversampling strobe, supplied from outside at sixteen strobes per bit by default, paces a small state machine that finds the start bit, samples each later bit at its centre, and optionally checks a parity bit. The data width is selectable from five to eight bits. Each completed character, together with its own error flags, goes into a receive queue whose depth is a parameter. The queue can also be reduced to a single holding slot.

Software-side logic drains the queue through a valid/ready read port. Every entry read carries the character and its flags. A separate four-bit error register keeps the framing, parity and break flags of the character most recently taken from the port. It also records queue overflow the moment that overflow happens. A one-cycle clear pulse zeroes this register.

The read port follows the usual stream rules. `rd_valid` is high whenever the queue holds an entry. The entry on `rd_data` is consumed on a clock edge where both `rd_valid` and `rd_ready` are high. While `rd_ready` stays low, the head entry's data and error bits stay unchanged. The receiver itself cannot be stalled: a character that arrives while the queue is full is dropped and flagged as an overflow.

Top module: `uart_rx_stat`

## Requirements
- R1: Each queue entry is 12 bits wide. Bits 7:0 hold the received data, first-received bit in bit 0, with unused upper bits zero. Bit 8 is the framing error, bit 9 the parity error, bit 10 break and bit 11 overflow.
- R2: `word_len` selects the data width: 2'b00 is 5 bits, 2'b01 is 6, 2'b10 is 7 and 2'b11 is 8.
- R3: With `par_en` high, one parity bit follows the data. When `par_stick` is low, `par_even`=1 expects an even count of ones over data and parity, and `par_even`=0 expects an odd count. When `par_stick` is high, the expected bit is 1 if `par_even`=0 and 0 if `par_even`=1. A mismatch sets bit 9.
- R4: Only the first stop bit is sampled, and a low sample sets bit 8. A new start bit may begin directly after that first stop bit.
- R5: A falling edge starts reception only if the line is still low eight strobes later. A shorter low pulse produces no entry.
- R6: A line held low through a whole frame (start, data, parity if enabled, and stop) produces a single entry 12'h500, with break and framing set and data zero. No further entry is produced until the line has returned high.
- R7: `rd_valid` is high while the queue holds an entry. An entry is consumed only when `rd_valid` and `rd_ready` are high at the same edge. While `rd_ready` is low, `rd_valid` and bits 10:0 of `rd_data` hold.
- R8: `err_stat` bit 0 (framing), bit 1 (parity) and bit 2 (break) load from the entry consumed at a read handshake. At any other time they keep their previous value.
- R9: A character arriving while the queue is full is discarded. It sets bit 11 of the most recently stored entry, and `err_stat` bit 3 is set on the next cycle without waiting for a read.
- R10: A one-cycle pulse on `err_clr` zeroes `err_stat`.
- R11: With `fifo_on` high the queue holds FIFO_DEPTH entries. With `fifo_on` low it holds one entry. `rx_full` and `rx_empty` refer to the capacity in use, and are never both high.
- R12: After reset `rx_empty`=1, `rx_full`=0, `rd_valid`=0 and `err_stat`=0.
- R13: `uart_on` and `rx_on` are looked at only when a start edge is found. Clearing either during a character lets that character complete. While either is low, no new character is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling strobe, OVS strobes per bit |
| rxd | input | 1 | Serial receive line, idle high |
| uart_on | input | 1 | Global enable |
| rx_on | input | 1 | Receive enable |
| word_len | input | 2 | Data width select |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity select |
| par_stick | input | 1 | Fixed parity value mode |
| fifo_on | input | 1 | Queue mode (1) or single holding slot (0) |
| rd_valid | output | 1 | Queue has an entry |
| rd_ready | input | 1 | Consumer accepts the head entry |
| rd_data | output | 12 | Head entry: data and error flags |
| err_stat | output | 4 | Error register {overflow, break, parity, framing} |
| err_clr | input | 1 | Clears the error register |
| rx_empty | output | 1 | No entry held |
| rx_full | output | 1 | Capacity in use reached |

## Verification
The bench instantiates the block with FIFO_DEPTH set to 4 and the default OVS of 16, and it pulses the strobe every fourth clock, so one bit lasts 64 clocks. The small depth means that four back-to-back characters fill the queue. A fifth one then reaches the overflow path, including the marking of the last stored entry, within a short run. The single-slot mode brings the same overflow path into reach after only two characters, and there the marked entry is also the head of the queue.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  // Queue entry: flags above the data byte, overflow at the top.
  typedef struct packed {
    logic       ovr;
    logic       brk;
    logic       par;
    logic       frm;
    logic [7:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    RXS_IDLE,
    RXS_START,
    RXS_DATA,
    RXS_PAR,
    RXS_STOP
  } rx_state_e;

endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      rxd,
  input  logic      accept_en,
  input  logic [1:0] wlen,
  input  logic      par_en,
  input  logic      par_even,
  input  logic      par_stick,
  output logic      push,
  output rx_entry_t entry
);

  localparam int CW = (OVS > 2) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] MID_LAST = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] BIT_LAST = CW'(OVS - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rxd_s;
  rx_state_e              state;
  logic [CW-1:0]          cnt;
  logic [2:0]             bit_idx;
  logic [2:0]             last_idx;
  logic [7:0]             shreg;
  logic                   low_all;
  logic                   par_bad;
  logic                   rx_last;
  logic                   exp_par;
  logic                   at_center;
  logic                   is_break;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
  end
  assign rxd_s = sync_q[SYNC_STAGES-1];

  assign last_idx  = 3'd4 + {1'b0, wlen};
  assign at_center = (cnt == BIT_LAST);
  assign exp_par   = par_stick ? ~par_even : (par_even ? ^shreg : ~^shreg);
  assign is_break  = low_all & ~rxd_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RXS_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      low_all <= 1'b0;
      par_bad <= 1'b0;
      rx_last <= 1'b1;
      push    <= 1'b0;
      entry   <= '0;
    end else begin
      push <= 1'b0;
      if (tick) begin
        rx_last <= rxd_s;
        unique case (state)
          RXS_IDLE: begin
            if (accept_en && rx_last && !rxd_s) begin
              state <= RXS_START;
              cnt   <= '0;
            end
          end
          RXS_START: begin
            if (cnt == MID_LAST) begin
              cnt <= '0;
              if (!rxd_s) begin
                state   <= RXS_DATA;
                bit_idx <= '0;
                shreg   <= '0;
                low_all <= 1'b1;
                par_bad <= 1'b0;
              end else begin
                state <= RXS_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RXS_DATA: begin
            if (at_center) begin
              cnt            <= '0;
              shreg[bit_idx] <= rxd_s;
              low_all        <= low_all & ~rxd_s;
              if (bit_idx == last_idx) state <= par_en ? RXS_PAR : RXS_STOP;
              else                     bit_idx <= bit_idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RXS_PAR: begin
            if (at_center) begin
              cnt     <= '0;
              par_bad <= (rxd_s != exp_par);
              low_all <= low_all & ~rxd_s;
              state   <= RXS_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RXS_STOP: begin
            if (at_center) begin
              cnt        <= '0;
              state      <= RXS_IDLE;
              push       <= 1'b1;
              entry.ovr  <= 1'b0;
              entry.brk  <= is_break;
              entry.frm  <= ~rxd_s;
              entry.par  <= ~is_break & par_en & par_bad;
              entry.data <= is_break ? 8'h00 : shreg;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= RXS_IDLE;
        endcase
      end
    end
  end

  AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !push);  // R1

  AST_BREAK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (push && entry.brk) |-> (entry.frm && !entry.par && entry.data == 8'h00));  // R6

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fifo_on,
  input  logic      wr_en,
  input  rx_entry_t wr_entry,
  output logic      ovf,
  output logic      rd_valid,
  input  logic      rd_ready,
  output rx_entry_t rd_entry,
  output logic      empty,
  output logic      full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] TOP_IDX = AW'(DEPTH - 1);

  rx_entry_t     mem [DEPTH];
  logic [AW-1:0] wptr, rptr, last_idx;
  logic [CW-1:0] count, cap;
  logic          do_wr, pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == TOP_IDX) ? '0 : p + 1'b1;
  endfunction

  assign cap      = fifo_on ? CW'(DEPTH) : CW'(1);
  assign full     = (count >= cap);
  assign empty    = (count == '0);
  assign rd_valid = ~empty;
  assign rd_entry = mem[rptr];
  assign pop      = rd_valid & rd_ready;
  assign do_wr    = wr_en & ~full;
  assign ovf      = wr_en & full;
  assign last_idx = (wptr == '0) ? TOP_IDX : wptr - 1'b1;

  always_ff @(posedge clk) begin
    if (do_wr)    mem[wptr]         <= wr_entry;
    else if (ovf) mem[last_idx].ovr <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_wr) wptr <= step(wptr);
      if (pop)   rptr <= step(rptr);
      count <= count + CW'(do_wr) - CW'(pop);
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));  // R11

  AST_NOT_EMPTY_AND_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));  // R11

  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_entry[10:0])));  // R7

endmodule

// File: rtl/uart_rx_stat.sv
module uart_rx_stat
  import uart_rx_pkg::*;
#(
  parameter int FIFO_DEPTH  = 16,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        os_tick,
  input  logic        rxd,
  input  logic        uart_on,
  input  logic        rx_on,
  input  logic [1:0]  word_len,
  input  logic        par_en,
  input  logic        par_even,
  input  logic        par_stick,
  input  logic        fifo_on,
  output logic        rd_valid,
  input  logic        rd_ready,
  output logic [11:0] rd_data,
  output logic [3:0]  err_stat,
  input  logic        err_clr,
  output logic        rx_empty,
  output logic        rx_full
);

  logic      push;
  rx_entry_t new_entry;
  rx_entry_t head;
  logic      ovf;
  logic      pop;

  uart_rx_frame #(
    .OVS         (OVS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (os_tick),
    .rxd       (rxd),
    .accept_en (uart_on & rx_on),
    .wlen      (word_len),
    .par_en    (par_en),
    .par_even  (par_even),
    .par_stick (par_stick),
    .push      (push),
    .entry     (new_entry)
  );

  uart_rx_fifo #(
    .DEPTH (FIFO_DEPTH)
  ) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .fifo_on  (fifo_on),
    .wr_en    (push),
    .wr_entry (new_entry),
    .ovf      (ovf),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .rd_entry (head),
    .empty    (rx_empty),
    .full     (rx_full)
  );

  assign rd_data = head;
  assign pop     = rd_valid & rd_ready;

  // err_stat: [3] overflow (immediate), [2] break, [1] parity, [0] framing.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_stat <= '0;
    end else if (err_clr) begin
      err_stat <= {ovf, 3'b000};
    end else begin
      if (pop) err_stat[2:0] <= {head.brk, head.par, head.frm};
      if (ovf) err_stat[3]   <= 1'b1;
    end
  end

  AST_OVR_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> err_stat[3]);  // R9

  AST_STAT_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop && !err_clr && !ovf) |=> $stable(err_stat));  // R8

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !ovf) |=> (err_stat == 4'b0000));  // R10

endmodule

// File: tb/sim_uart_rx_stat.sv
module sim_uart_rx_stat;

  localparam int DEPTH   = 4;
  localparam int BIT_CLK = 64;

  typedef struct packed {
    logic [1:0] wl;
    logic       pen;
    logic       pev;
    logic       pst;
    logic [7:0] d;
    logic       flip;
    logic       bstop;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VEC [NVEC] = '{
    '{2'd3, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0},
    '{2'd0, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0},
    '{2'd1, 1'b0, 1'b0, 1'b0, 8'hEC, 1'b0, 1'b0},
    '{2'd2, 1'b1, 1'b1, 1'b0, 8'h55, 1'b0, 1'b0},
    '{2'd3, 1'b1, 1'b0, 1'b0, 8'h81, 1'b1, 1'b0},
    '{2'd3, 1'b1, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b0},
    '{2'd3, 1'b1, 1'b1, 1'b1, 8'h3C, 1'b1, 1'b0},
    '{2'd3, 1'b0, 1'b0, 1'b0, 8'h5A, 1'b0, 1'b1},
    '{2'd2, 1'b1, 1'b1, 1'b0, 8'h7F, 1'b1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  tdiv = 2'd0;
  logic        os_tick;
  logic        rxd = 1'b1;
  logic        uart_on = 1'b1;
  logic        rx_on = 1'b1;
  logic [1:0]  word_len = 2'd3;
  logic        par_en = 1'b0;
  logic        par_even = 1'b0;
  logic        par_stick = 1'b0;
  logic        fifo_on = 1'b1;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [11:0] rd_data;
  logic [3:0]  err_stat;
  logic        err_clr = 1'b0;
  logic        rx_empty;
  logic        rx_full;

  int checks = 0;
  int fails  = 0;
  logic [11:0] got;

  always #2.5 clk = ~clk;

  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign os_tick = (tdiv == 2'd3);

  uart_rx_stat #(.FIFO_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
    .uart_on(uart_on), .rx_on(rx_on), .word_len(word_len),
    .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
    .fifo_on(fifo_on), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .err_stat(err_stat), .err_clr(err_clr),
    .rx_empty(rx_empty), .rx_full(rx_full)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive_bit(input logic v);
    rxd = v;
    repeat (BIT_CLK) @(negedge clk);
  endtask

  function automatic logic [7:0] masked(input vec_t v);
    return v.d & (8'hFF >> (2'd3 - v.wl));
  endfunction

  function automatic logic [11:0] model(input vec_t v);
    return {1'b0, 1'b0, v.pen & v.flip, v.bstop, masked(v)};
  endfunction

  task automatic send_frame(input vec_t v);
    logic [7:0] dm;
    logic       p;
    dm        = masked(v);
    word_len  = v.wl;
    par_en    = v.pen;
    par_even  = v.pev;
    par_stick = v.pst;
    p = v.pst ? ~v.pev : (v.pev ? ^dm : ~^dm);
    drive_bit(1'b0);
    for (int i = 0; i < 5 + int'(v.wl); i++) drive_bit(dm[i]);
    if (v.pen) drive_bit(p ^ v.flip);
    drive_bit(~v.bstop);
  endtask

  function automatic vec_t plain8(input logic [7:0] d);
    return '{2'd3, 1'b0, 1'b0, 1'b0, d, 1'b0, 1'b0};
  endfunction

  task automatic read_one(output logic [11:0] v);
    v = rd_data;
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic pulse_clr();
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R12: state right after reset
    chk("R12 empty", 16'(rx_empty), 16'd1);
    chk("R12 full", 16'(rx_full), 16'd0);
    chk("R12 valid", 16'(rd_valid), 16'd0);
    chk("R12 stat", 16'(err_stat), 16'd0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);

    // Table: R1 R2 R3 R4 R8 per vector
    for (int k = 0; k < NVEC; k++) begin
      send_frame(VEC[k]);
      drive_bit(1'b1);
      chk("R7 valid after frame", 16'(rd_valid), 16'd1);
      read_one(got);
      chk("R1 R2 R3 R4 entry", 16'(got), 16'(model(VEC[k])));
      chk("R8 stat from read", 16'(err_stat), {13'd0, model(VEC[k])[10:8]});
    end

    // R8: status register waits for the data read
    send_frame(plain8(8'h11));
    drive_bit(1'b1);
    chk("R8 stat before read", 16'(err_stat), 16'h0002);
    read_one(got);
    chk("R8 stat after read", 16'(err_stat), 16'h0000);

    // R10: clear
    send_frame('{2'd3, 1'b0, 1'b0, 1'b0, 8'h22, 1'b0, 1'b1});
    drive_bit(1'b1);
    read_one(got);
    chk("R8 framing loaded", 16'(err_stat), 16'h0001);
    pulse_clr();
    chk("R10 clear", 16'(err_stat), 16'h0000);

    // R7: hold under back-pressure
    send_frame(plain8(8'h33));
    drive_bit(1'b1);
    repeat (10) @(negedge clk);
    chk("R7 valid held", 16'(rd_valid), 16'd1);
    chk("R7 data held", 16'(rd_data), 16'h0033);
    read_one(got);
    chk("R7 empty after read", 16'(rx_empty), 16'd1);

    // R4: start immediately after the first stop bit
    send_frame(plain8(8'h12));
    send_frame(plain8(8'h34));
    drive_bit(1'b1);
    read_one(got);
    chk("R4 first", 16'(got), 16'h0012);
    read_one(got);
    chk("R4 second", 16'(got), 16'h0034);

    // R5: short low pulse is rejected
    rxd = 1'b0;
    repeat (16) @(negedge clk);
    drive_bit(1'b1);
    drive_bit(1'b1);
    chk("R5 glitch ignored", 16'(rx_empty), 16'd1);

    // R6: break
    word_len = 2'd3; par_en = 1'b0;
    for (int i = 0; i < 11; i++) drive_bit(1'b0);
    drive_bit(1'b1);
    drive_bit(1'b1);
    read_one(got);
    chk("R6 break entry", 16'(got), 16'h0500);
    chk("R6 single entry", 16'(rx_empty), 16'd1);
    chk("R6 break stat", 16'(err_stat), 16'h0005);
    pulse_clr();

    // R11 + R9 in queue mode
    for (int i = 0; i < DEPTH; i++) send_frame(plain8(8'(8'h40 + i)));
    drive_bit(1'b1);
    chk("R11 full at depth", 16'(rx_full), 16'd1);
    send_frame(plain8(8'h44));
    drive_bit(1'b1);
    chk("R9 overflow immediate", 16'(err_stat), 16'h0008);
    for (int i = 0; i < DEPTH; i++) begin
      read_one(got);
      chk("R9 queue order", 16'(got),
          (i == DEPTH - 1) ? 16'(12'h800 | (8'h40 + i)) : 16'(8'h40 + i));
    end
    chk("R9 dropped char", 16'(rx_empty), 16'd1);
    pulse_clr();

    // R11 + R9 in single-slot mode
    fifo_on = 1'b0;
    send_frame(plain8(8'h61));
    drive_bit(1'b1);
    chk("R11 single slot full", 16'(rx_full), 16'd1);
    send_frame(plain8(8'h62));
    drive_bit(1'b1);
    read_one(got);
    chk("R9 slot overflow mark", 16'(got), 16'h0861);
    chk("R11 slot empty", 16'(rx_empty), 16'd1);
    fifo_on = 1'b1;
    pulse_clr();

    // R13: disable mid-character, then disabled reception
    fork
      send_frame(plain8(8'h77));
      begin
        repeat (2 * BIT_CLK) @(negedge clk);
        rx_on = 1'b0;
      end
    join
    drive_bit(1'b1);
    read_one(got);
    chk("R13 char completes", 16'(got), 16'h0077);
    send_frame(plain8(8'h78));
    drive_bit(1'b1);
    chk("R13 rx_on low ignores", 16'(rx_empty), 16'd1);
    rx_on = 1'b1;
    uart_on = 1'b0;
    send_frame(plain8(8'h79));
    drive_bit(1'b1);
    chk("R13 uart_on low ignores", 16'(rx_empty), 16'd1);
    uart_on = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule